// File: doc/BRIEF.md
# Transport Packet Length-Policing Receiver

This block takes in a byte-wide packet stream, framed by a start marker and an end marker, and measures each packet against a nominal length. A mode input sets that length to 188 or 192 bytes. A packet of exactly the nominal length is stored in an internal receive FIFO. A packet longer than nominal is cut to the nominal length, and the cut packet is stored. A packet shorter than nominal is dropped entirely.

Bytes go into the FIFO at a tentative write position. The consumer can see them only after the packet's end marker commits them. A packet that fills the FIFO is therefore removed whole, and packets stored before it are not touched. A packet that is dropped or aborted is removed in the same way.

Three saturating counters record the packets. One counts stored packets, one counts truncated packets and one counts dropped short packets. A free-running time stamp counter raises a flag when it wraps after the most recent stored packet. Four write-1-to-clear status flags, each with its own enable bit, drive one interrupt line.

Top module: `tsp_len_rx`

## Requirements
- R1: With `mode_b`=0 the nominal length is 188 bytes; with `mode_b`=1 it is 192 bytes. A packet of exactly nominal length is committed to the FIFO with its bytes in arrival order. It increments the packet counter and sets neither the long flag nor the short flag.
- R2: A packet longer than nominal commits only its first nominal-length bytes and discards the rest. It increments both the packet counter and the long counter. It sets the long flag, which is status bit 9.
- R3: A packet shorter than nominal leaves nothing in the FIFO. It increments only the short counter and sets the short flag, which is status bit 8.
- R4: If a packet's bytes would exceed the FIFO depth, the overflow flag (status bit 4) is set at that packet's end. That packet is discarded and the packet counter does not count it. Every packet committed earlier stays readable and unchanged.
- R5: The wrap flag (status bit 0) is set when the time stamp counter reaches all-ones for the first time after a committed packet. It is set only once per committed packet. It is never set before the first committed packet.
- R6: The status flags reset to 0. Writing address 0 clears each flag whose write-data bit is 1 and leaves the other flags unchanged. If hardware sets a flag in the same cycle that software clears it, the flag ends up set.
- R7: Register map (`reg_addr`): 0 is status, 1 is interrupt enable (same bit positions as status), 2 is the packet counter, 3 is the long counter and 4 is the short counter. In status and enable, every bit other than 9, 8, 4 and 0 always reads 0, and writes to those bits have no effect.
- R8: `irq` is 1 exactly when some status flag is 1 and its enable bit is also 1.
- R9: Each counter is CNT_W bits wide and holds at its maximum value instead of wrapping. A write to a counter's address clears that counter to 0.
- R10: A start marker that arrives while a packet is still open discards the open packet's bytes. Bytes that arrive with `in_valid` outside any packet are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_b | input | 1 | Nominal length select: 0 selects 188 bytes, 1 selects 192 bytes |
| in_valid | input | 1 | Stream byte valid |
| in_sop | input | 1 | First byte of a packet |
| in_eop | input | 1 | Last byte of a packet |
| in_data | input | DW | Stream byte |
| fifo_rd | input | 1 | Pop one committed byte |
| fifo_rdata | output | DW | Oldest committed byte |
| fifo_empty | output | 1 | No committed byte available |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 12 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from `reg_addr` |
| irq | output | 1 | Interrupt |

## Verification
The main function is driven with packets of exactly nominal length, of one byte below nominal and of one byte above nominal, in both modes. These separate the three classes at their boundaries and show that the mode input moves the boundary. A packet of 192 bytes sent in 188 mode must be classed as long, while the same packet in 192 mode is good. Very long packets and one-byte packets check that truncation keeps the correct prefix and that the shortest possible packet is dropped. Three packets back to back overflow the FIFO, and an unterminated packet followed by a new start checks rollback: in both cases the bytes read out show whether the earlier data survived.

// File: rtl/tsp_len_rx_pkg.sv
package tsp_len_rx_pkg;
   localparam int FLG_LONG  = 9;
   localparam int FLG_SHORT = 8;
   localparam int FLG_ROVF  = 4;
   localparam int FLG_TSTO  = 0;
   localparam int STS_W     = 12;
   localparam logic [STS_W-1:0] FLG_MASK = 12'h311;

   typedef enum logic [2:0] {
      RA_STATUS = 3'd0,
      RA_ENABLE = 3'd1,
      RA_NPKT   = 3'd2,
      RA_NLONG  = 3'd3,
      RA_NSHORT = 3'd4
   } reg_addr_e;

   typedef struct packed {
      logic done;
      logic is_short;
      logic is_long;
      logic ovf;
   } pkt_evt_t;
endpackage

// File: rtl/tsp_len_track.sv
module tsp_len_track
   import tsp_len_rx_pkg::*;
#(
   parameter int NOM_A = 188,
   parameter int NOM_B = 192
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     mode_b,
   input  logic     in_valid,
   input  logic     in_sop,
   input  logic     in_eop,
   input  logic     fifo_full,
   output logic     byte_we,
   output logic     abort,
   output pkt_evt_t evt
);
   localparam int LEN_W = $clog2(NOM_B + 3);
   localparam logic [LEN_W-1:0] CAP = LEN_W'(NOM_B + 1);

   logic             in_pkt;
   logic             ovf_seen;
   logic [LEN_W-1:0] idx;
   logic [LEN_W-1:0] nom, cur, len;
   logic             active, ovf_pkt;

   always_comb begin
      nom     = mode_b ? LEN_W'(NOM_B) : LEN_W'(NOM_A);
      active  = in_valid && (in_sop || in_pkt);
      cur     = in_sop ? '0 : idx;
      len     = (cur < CAP) ? cur + 1'b1 : CAP;
      byte_we = active && (cur < nom) && !(ovf_seen && !in_sop);
      abort   = in_valid && in_sop && in_pkt;
      ovf_pkt = (ovf_seen && !in_sop) || (byte_we && fifo_full);
      evt.done     = active && in_eop;
      evt.is_short = len < nom;
      evt.is_long  = len > nom;
      evt.ovf      = ovf_pkt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         in_pkt   <= 1'b0;
         idx      <= '0;
         ovf_seen <= 1'b0;
      end else if (active) begin
         if (in_eop) begin
            in_pkt   <= 1'b0;
            idx      <= '0;
            ovf_seen <= 1'b0;
         end else begin
            in_pkt   <= 1'b1;
            idx      <= len;
            ovf_seen <= ovf_pkt;
         end
      end
   end
endmodule

// File: rtl/tsp_roll_fifo.sv
module tsp_roll_fifo #(
   parameter int DW    = 8,
   parameter int DEPTH = 512
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we,
   input  logic [DW-1:0] wdata,
   input  logic          abort,
   input  logic          commit,
   input  logic          rollback,
   input  logic          rd,
   output logic [DW-1:0] rdata,
   output logic          empty,
   output logic          full
);
   localparam int AW = $clog2(DEPTH);
   localparam logic [AW:0] FULLV = {1'b1, {AW{1'b0}}};

   if ((1 << AW) != DEPTH) begin : g_bad_depth
      $error("tsp_roll_fifo: DEPTH must be a power of two");
   end

   logic [DW-1:0] mem [DEPTH];
   logic [AW:0]   rptr, wcom, wtent;
   logic [AW:0]   base, after;
   logic          wr_ok, pop;

   always_comb begin
      base  = abort ? wcom : wtent;
      full  = (base - rptr) == FULLV;
      wr_ok = we && !full;
      after = base + {{AW{1'b0}}, wr_ok};
      empty = rptr == wcom;
      pop   = rd && !empty;
      rdata = mem[rptr[AW-1:0]];
   end

   always_ff @(posedge clk) begin
      if (wr_ok) mem[base[AW-1:0]] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rptr  <= '0;
         wcom  <= '0;
         wtent <= '0;
      end else begin
         rptr <= rptr + {{AW{1'b0}}, pop};
         if (commit) begin
            wcom  <= after;
            wtent <= after;
         end else if (rollback) begin
            wtent <= wcom;
         end else begin
            wtent <= after;
         end
      end
   end
endmodule

// File: rtl/tsp_ts_wrap.sv
module tsp_ts_wrap #(
   parameter int TS_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            arm,
   output logic            wrap_hit,
   output logic [TS_W-1:0] ts_val
);
   logic armed;
   logic terminal;

   always_comb begin
      terminal = &ts_val;
      wrap_hit = terminal && armed;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ts_val <= '0;
         armed  <= 1'b0;
      end else begin
         ts_val <= ts_val + 1'b1;
         if (arm)           armed <= 1'b1;
         else if (terminal) armed <= 1'b0;
      end
   end
endmodule

// File: rtl/tsp_len_rx.sv
module tsp_len_rx
   import tsp_len_rx_pkg::*;
#(
   parameter int NOM_A = 188,
   parameter int NOM_B = 192,
   parameter int DW    = 8,
   parameter int DEPTH = 512,
   parameter int TS_W  = 16,
   parameter int CNT_W = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          mode_b,
   input  logic          in_valid,
   input  logic          in_sop,
   input  logic          in_eop,
   input  logic [DW-1:0] in_data,
   input  logic          fifo_rd,
   output logic [DW-1:0] fifo_rdata,
   output logic          fifo_empty,
   input  logic          reg_wr,
   input  logic [2:0]    reg_addr,
   input  logic [11:0]   reg_wdata,
   output logic [15:0]   reg_rdata,
   output logic          irq
);
   localparam int NCNT = 3;
   localparam logic [2:0] CNT_ADDR [NCNT] = '{RA_NPKT, RA_NLONG, RA_NSHORT};

   if (DEPTH < NOM_B) begin : g_bad_fifo
      $error("tsp_len_rx: FIFO must hold at least one packet");
   end
   if (NOM_A >= NOM_B) begin : g_bad_nom
      $error("tsp_len_rx: NOM_A must be below NOM_B");
   end
   if (CNT_W > 16 || CNT_W < 1) begin : g_bad_cnt
      $error("tsp_len_rx: CNT_W must be 1..16");
   end

   pkt_evt_t         evt;
   logic             byte_we, abort, fifo_full;
   logic             commit, rollback, wrap_hit;
   logic             evt_done, evt_short, evt_long, evt_ovf;
   logic [TS_W-1:0]  ts_val;
   logic [STS_W-1:0] sts_q, en_q, set_v, clr_v;
   logic [NCNT-1:0]  inc_v;
   logic [CNT_W-1:0] cnt_rd [NCNT];

   tsp_len_track #(.NOM_A(NOM_A), .NOM_B(NOM_B)) u_track (
      .clk(clk), .rst_n(rst_n), .mode_b(mode_b), .in_valid(in_valid),
      .in_sop(in_sop), .in_eop(in_eop), .fifo_full(fifo_full),
      .byte_we(byte_we), .abort(abort), .evt(evt)
   );

   always_comb begin
      evt_done  = evt.done;
      evt_short = evt.is_short;
      evt_long  = evt.is_long;
      evt_ovf   = evt.ovf;
      commit    = evt_done && !evt_short && !evt_ovf;
      rollback  = evt_done && (evt_short || evt_ovf);
   end

   tsp_roll_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .we(byte_we), .wdata(in_data), .abort(abort),
      .commit(commit), .rollback(rollback), .rd(fifo_rd),
      .rdata(fifo_rdata), .empty(fifo_empty), .full(fifo_full)
   );

   tsp_ts_wrap #(.TS_W(TS_W)) u_ts (
      .clk(clk), .rst_n(rst_n), .arm(commit), .wrap_hit(wrap_hit), .ts_val(ts_val)
   );

   always_comb begin
      set_v = '0;
      set_v[FLG_LONG]  = commit && evt_long;
      set_v[FLG_SHORT] = evt_done && evt_short;
      set_v[FLG_ROVF]  = evt_done && !evt_short && evt_ovf;
      set_v[FLG_TSTO]  = wrap_hit;
      clr_v = (reg_wr && reg_addr == RA_STATUS) ? (reg_wdata & FLG_MASK) : '0;
      inc_v = {evt_done && evt_short, commit && evt_long, commit};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q <= '0;
         en_q  <= '0;
      end else begin
         sts_q <= ((sts_q & ~clr_v) | set_v) & FLG_MASK;
         if (reg_wr && reg_addr == RA_ENABLE) en_q <= reg_wdata & FLG_MASK;
      end
   end

   for (genvar k = 0; k < NCNT; k++) begin : g_cnt
      logic [CNT_W-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                               q <= '0;
         else if (reg_wr && reg_addr == CNT_ADDR[k]) q <= '0;
         else if (inc_v[k] && q != '1)             q <= q + 1'b1;
      end
      assign cnt_rd[k] = q;
   end

   always_comb begin
      case (reg_addr)
         RA_STATUS: reg_rdata = 16'(sts_q);
         RA_ENABLE: reg_rdata = 16'(en_q);
         RA_NPKT:   reg_rdata = 16'(cnt_rd[0]);
         RA_NLONG:  reg_rdata = 16'(cnt_rd[1]);
         RA_NSHORT: reg_rdata = 16'(cnt_rd[2]);
         default:   reg_rdata = '0;
      endcase
      irq = |(sts_q & en_q);
   end
endmodule

// File: rtl/tsp_len_rx_chk.sv
module tsp_len_rx_chk #(
   parameter int TS_W = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            reg_wr,
   input logic [2:0]      reg_addr,
   input logic [11:0]     reg_wdata,
   input logic [15:0]     reg_rdata,
   input logic [11:0]     sts,
   input logic            evt_done,
   input logic            evt_short,
   input logic            evt_long,
   input logic            evt_ovf,
   input logic [TS_W-1:0] ts_val
);
   AST_LONG_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_done && !evt_short && !evt_ovf && evt_long) |=> sts[9]); // R2
   AST_SHORT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_done && evt_short) |=> sts[8]); // R3
   AST_OVF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_done && !evt_short && evt_ovf) |=> sts[4]); // R4
   AST_WRAP_AT_TERMINAL: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sts[0]) |-> $past(&ts_val)); // R5
   AST_LONG_W1C_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sts[9]) |-> $past(reg_wr && reg_addr == 3'd0 && reg_wdata[9])); // R6
   AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_addr == 3'd0) |-> ((reg_rdata & 16'hFCEE) == 16'h0)); // R7
endmodule

bind tsp_len_rx tsp_len_rx_chk #(.TS_W(TS_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
   .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sts(sts_q),
   .evt_done(evt_done), .evt_short(evt_short), .evt_long(evt_long),
   .evt_ovf(evt_ovf), .ts_val(ts_val)
);

// File: tb/tsp_len_rx_bench.sv
module tsp_len_rx_bench;
   localparam int DEPTH = 512;
   localparam int TS_W  = 10;
   localparam int CNT_W = 4;
   localparam int NV    = 8;
   localparam int VLEN  [NV] = '{188, 192, 200, 187, 192, 191, 1, 300};
   localparam bit VMODE [NV] = '{0, 1, 1, 0, 0, 1, 1, 0};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode_b = 1'b0, in_valid = 1'b0, in_sop = 1'b0, in_eop = 1'b0;
   logic [7:0]  in_data = '0;
   logic        fifo_rd = 1'b0;
   logic [7:0]  fifo_rdata;
   logic        fifo_empty;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [11:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        irq;
   int n_chk = 0, n_bad = 0;

   always #2 clk = ~clk;

   tsp_len_rx #(.DEPTH(DEPTH), .TS_W(TS_W), .CNT_W(CNT_W)) u_tsp_len_rx (
      .clk(clk), .rst_n(rst_n), .mode_b(mode_b), .in_valid(in_valid),
      .in_sop(in_sop), .in_eop(in_eop), .in_data(in_data), .fifo_rd(fifo_rd),
      .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty), .reg_wr(reg_wr),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [15:0] v);
      @(negedge clk);
      reg_addr = a;
      #1 v = reg_rdata;
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [11:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic send_pkt(input int len, input logic [7:0] tag, input bit with_eop);
      for (int i = 0; i < len; i++) begin
         @(negedge clk);
         in_valid = 1'b1; in_sop = (i == 0); in_eop = (i == len - 1) && with_eop;
         in_data = 8'(int'(tag) + i);
      end
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0;
   endtask

   task automatic drain(input int n, input logic [7:0] tag, input string req);
      int bad = 0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (fifo_empty !== 1'b0 || fifo_rdata !== 8'(int'(tag) + i)) bad++;
         fifo_rd = 1'b1;
      end
      @(negedge clk);
      fifo_rd = 1'b0;
      check(req, bad, 0);
   endtask

   task automatic clear_all();
      wr_reg(3'd0, 12'hFFF);
      wr_reg(3'd2, 12'h0);
      wr_reg(3'd3, 12'h0);
      wr_reg(3'd4, 12'h0);
   endtask

   initial begin : watchdog
      repeat (190000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin : main
      logic [15:0] v;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;

      // reset state (R6, R9)
      rd_reg(3'd0, v); check("R6 status after reset", v, 0);
      rd_reg(3'd2, v); check("R9 packet count after reset", v, 0);
      rd_reg(3'd4, v); check("R9 short count after reset", v, 0);
      check("R8 irq after reset", irq, 0);
      check("R1 fifo empty after reset", fifo_empty, 1);

      // R5: no wrap flag before any committed packet
      repeat ((1 << TS_W) + 20) @(negedge clk);
      rd_reg(3'd0, v); check("R5 no wrap before first packet", v[0], 0);

      // vector table walk: R1, R2, R3
      for (int k = 0; k < NV; k++) begin
         int nom;
         bit is_s, is_l;
         nom  = VMODE[k] ? 192 : 188;
         is_s = VLEN[k] < nom;
         is_l = VLEN[k] > nom;
         clear_all();
         mode_b = VMODE[k];
         send_pkt(VLEN[k], 8'(k * 16), 1'b1);
         rd_reg(3'd0, v);
         check($sformatf("R2/R3 flags vec%0d", k), {v[9], v[8], v[4]}, {is_l, is_s, 1'b0});
         rd_reg(3'd2, v); check($sformatf("R1 packet count vec%0d", k), v, is_s ? 0 : 1);
         rd_reg(3'd3, v); check($sformatf("R2 long count vec%0d", k), v, is_l ? 1 : 0);
         rd_reg(3'd4, v); check($sformatf("R3 short count vec%0d", k), v, is_s ? 1 : 0);
         if (!is_s) drain(nom, 8'(k * 16), $sformatf("R1/R2 fifo bytes vec%0d", k));
         check($sformatf("R3 fifo empty vec%0d", k), fifo_empty, 1);
      end

      // R5: wrap flag after a committed packet, once only
      mode_b = 1'b0;
      clear_all();
      send_pkt(188, 8'h11, 1'b1);
      drain(188, 8'h11, "R1 wrap setup bytes");
      repeat ((1 << TS_W) + 20) @(negedge clk);
      rd_reg(3'd0, v); check("R5 wrap flag after packet", v[0], 1);
      wr_reg(3'd0, 12'h001);
      repeat ((1 << TS_W) + 20) @(negedge clk);
      rd_reg(3'd0, v); check("R5 wrap flag only once", v[0], 0);

      // R4: overflow keeps earlier packets
      clear_all();
      send_pkt(188, 8'h10, 1'b1);
      send_pkt(188, 8'h20, 1'b1);
      send_pkt(188, 8'h30, 1'b1);
      rd_reg(3'd0, v); check("R4 overflow flag", v[4], 1);
      rd_reg(3'd2, v); check("R4 packet count excludes overflow", v, 2);
      drain(188, 8'h10, "R4 first packet intact");
      drain(188, 8'h20, "R4 second packet intact");
      check("R4 overflowing packet removed", fifo_empty, 1);

      // R10: stray bytes ignored, open packet aborted by new start
      clear_all();
      for (int i = 0; i < 5; i++) begin
         @(negedge clk); in_valid = 1'b1; in_data = 8'hEE;
      end
      @(negedge clk); in_valid = 1'b0;
      check("R10 stray bytes ignored", fifo_empty, 1);
      send_pkt(50, 8'h40, 1'b0);
      send_pkt(188, 8'h50, 1'b1);
      rd_reg(3'd2, v); check("R10 count after abort", v, 1);
      drain(188, 8'h50, "R10 only new packet kept");
      check("R10 fifo empty after abort", fifo_empty, 1);

      // R6: write-1-to-clear
      clear_all();
      send_pkt(1, 8'h00, 1'b1);
      wr_reg(3'd0, 12'h000);
      rd_reg(3'd0, v); check("R6 write 0 keeps flag", v[8], 1);
      wr_reg(3'd0, 12'h200);
      rd_reg(3'd0, v); check("R6 other bit write keeps flag", v[8], 1);
      wr_reg(3'd0, 12'h100);
      rd_reg(3'd0, v); check("R6 write 1 clears flag", v[8], 0);

      // R6: set wins over same-cycle clear
      @(negedge clk);
      in_valid = 1'b1; in_sop = 1'b1; in_eop = 1'b1; in_data = 8'h00;
      reg_wr = 1'b1; reg_addr = 3'd0; reg_wdata = 12'h100;
      @(negedge clk);
      in_valid = 1'b0; in_sop = 1'b0; in_eop = 1'b0; reg_wr = 1'b0;
      rd_reg(3'd0, v); check("R6 set wins over clear", v[8], 1);

      // R8: interrupt gating (short flag is set here)
      wr_reg(3'd1, 12'h000);
      #1 check("R8 irq masked", irq, 0);
      wr_reg(3'd1, 12'h100);
      #1 check("R8 irq enabled", irq, 1);
      wr_reg(3'd1, 12'h200);
      #1 check("R8 irq other enable", irq, 0);
      wr_reg(3'd1, 12'h100);
      wr_reg(3'd0, 12'h100);
      #1 check("R8 irq after clear", irq, 0);

      // R7: reserved bits
      wr_reg(3'd1, 12'hFFF);
      rd_reg(3'd1, v); check("R7 enable reserved bits", v, 16'h0311);
      send_pkt(1, 8'h00, 1'b1);
      rd_reg(3'd0, v); check("R7 status reserved bits", v & 16'hFCEE, 0);
      wr_reg(3'd1, 12'h000);

      // R9: saturation and clear
      clear_all();
      for (int i = 0; i < 20; i++) send_pkt(1, 8'h00, 1'b1);
      rd_reg(3'd4, v); check("R9 short count saturates", v, (1 << CNT_W) - 1);
      wr_reg(3'd4, 12'h000);
      rd_reg(3'd4, v); check("R9 short count cleared", v, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule